// File: doc/BRIEF.md
# Piecewise-Linear Gamma Curve Unit

This block is a streaming pixel transform that turns a 12-bit linear sample into a 10-bit display code. It uses a programmable curve made of 32 straight segments. The 33 segment ends (knots) sit at fixed input positions. These positions are eight apart below 64. Above 64 the spacing doubles after every group of four segments. Every segment width is therefore a power of two, so the fraction within a segment comes from masking the low input bits and the division is a right shift.

The output value at each knot is a 10-bit register. The host writes these registers through a simple write port. Writes go into a shadow copy of the curve. The live curve only takes the shadow values on a frame-start pulse, so a picture is never drawn with half of an old curve and half of a new one. The same rule applies to a fade-to-black request. While fade is active, every knot reads as zero and the whole picture goes black.

A two-state machine tracks whether the shadow holds anything that has not yet been copied. It starts in SH_SYNCED. An accepted knot write moves it from SH_SYNCED to SH_PENDING. A frame-start pulse with no write in the same cycle moves it from SH_PENDING back to SH_SYNCED, and that is the frame start on which the shadow is copied to the live curve. A frame start that coincides with a write copies the older shadow contents and stays in SH_PENDING, so the new write goes out on the next frame start. Pixels pass through three register stages, in this order:
- segment decode and knot lookup,
- signed multiply,
- round and clamp.

Top module: `gamma_pwl`

## Requirements
- R1: The knot input positions are 0,8,16,24,32,40,48,56,64,80,96,112,128,160,192,224,256,320,384,448,512,640,768,896,1024,1280,1536,1792,2048,2560,3072,3584,4096. An input x with pos[k] <= x < pos[k+1] uses segment k, with knots k and k+1. The input 4095 uses segment 31.
- R2: For segment k, with width w = pos[k+1]-pos[k], the output is y[k] + floor((( y[k+1]-y[k]) * (x-pos[k]) + w/2) / w), clamped to 0..1023. An input exactly on a knot gives y[k].
- R3: After reset, knot k holds min(pos[k]/4, 1023) in both the shadow and the live curve, and fade is off.
- R4: A cycle with wr_en high and wr_addr in 0..32 loads wr_data into shadow knot wr_addr. Writes to addresses 33..63 change nothing.
- R5: The live curve changes only on a frame_start pulse, and only then takes the shadow values. A pixel presented in the same cycle as frame_start still uses the old curve.
- R6: fade_en is sampled only on a frame_start pulse. While the sampled value is 1, every output pixel is 0.
- R7: out_valid equals in_valid delayed by exactly 3 clock cycles. out_pix is 0 whenever out_valid is low. Consecutive input pixels come out on consecutive cycles.
- R8: A segment where y[k+1] < y[k] interpolates downward with the same rounding rule as R2, and the output never goes outside the range of the two knot values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at the start of a frame; copies the shadow to the live curve |
| fade_en | input | 1 | Fade-to-black request, sampled on frame_start |
| wr_en | input | 1 | Knot write strobe |
| wr_addr | input | 6 | Knot index to write (0..32 valid) |
| wr_data | input | 10 | Knot output value |
| in_valid | input | 1 | Input pixel valid |
| in_pix | input | 12 | Linear input pixel |
| out_valid | output | 1 | Output pixel valid, 3 cycles after in_valid |
| out_pix | output | 10 | Gamma-mapped output pixel |

## Verification
The bench checks inputs on both sides of the places where the segment width changes. These include 63/64, 79/80 and 2047/2048, plus the top input 4095. A wrong priority decode or a wrong shift amount would pick the neighbouring segment there, or would scale the fraction by the wrong width.

It also loads a falling curve and a pair of knots that puts the result exactly halfway between two output codes. A design that used the difference as unsigned, or that rounded toward zero, would then wrap to a large value or come out one code off.

For the shadow path, the bench writes knots with no frame start and with out-of-range addresses, and presents a pixel in the same cycle as frame_start. A design that copied too early, or that decoded only the low address bits, would change the picture when it should not.

A back-to-back pixel burst shows any off-by-one in the valid delay.

// File: rtl/gamma_pkg.sv
package gamma_pkg;

    localparam int IN_W       = 12;
    localparam int OUT_W      = 10;
    localparam int N_KNOT     = 33;
    localparam int N_SEG      = N_KNOT - 1;
    localparam int SEG_W      = $clog2(N_SEG);
    localparam int ADDR_W     = $clog2(N_KNOT);
    localparam int FINE_SHIFT = 3;
    localparam int FINE_SEGS  = 8;
    localparam int SUB_BITS   = 2;
    localparam int FINE_LIMIT = FINE_SHIFT + $clog2(FINE_SEGS);
    localparam int SHIFT_W    = $clog2(IN_W);
    localparam int FRAC_W     = IN_W - SUB_BITS - 1;
    localparam int OUT_MAX    = (1 << OUT_W) - 1;
    localparam int PROD_W     = OUT_W + 1 + FRAC_W + 1;
    localparam int SUM_W      = PROD_W + 1;

    typedef logic [OUT_W-1:0]              knot_t;
    typedef logic [N_KNOT-1:0][OUT_W-1:0]  curve_t;

    typedef enum logic {
        SH_SYNCED  = 1'b0,
        SH_PENDING = 1'b1
    } sh_state_t;

    function automatic int knot_pos(input int k);
        int g;
        int r;
        if (k <= FINE_SEGS) begin
            return k << FINE_SHIFT;
        end
        g = (k - FINE_SEGS) >> SUB_BITS;
        r = (k - FINE_SEGS) & ((1 << SUB_BITS) - 1);
        return ((FINE_SEGS << FINE_SHIFT) << g)
             + r * (((FINE_SEGS << FINE_SHIFT) >> SUB_BITS) << g);
    endfunction

    function automatic int knot_reset(input int k);
        int p;
        p = knot_pos(k) >> (IN_W - OUT_W);
        return (p > OUT_MAX) ? OUT_MAX : p;
    endfunction

endpackage

// File: rtl/gamma_shadow_regs.sv
module gamma_shadow_regs
    import gamma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [OUT_W-1:0]  wr_data,
    input  logic              fade_en,
    input  logic              frame_start,
    output curve_t            active,
    output logic              fade_act
);

    sh_state_t state_q;
    sh_state_t state_d;
    curve_t    shadow;
    logic      wr_hit;
    logic      do_copy;

    assign wr_hit  = wr_en && (int'(wr_addr) < N_KNOT);
    assign do_copy = frame_start && (state_q == SH_PENDING);

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_SYNCED: begin
                if (wr_hit) state_d = SH_PENDING;
            end
            SH_PENDING: begin
                if (frame_start && !wr_hit) state_d = SH_SYNCED;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SH_SYNCED;
        else        state_q <= state_d;
    end

    // outputs: shadow and live curve
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < N_KNOT; k++) begin
                shadow[k] <= OUT_W'(knot_reset(k));
                active[k] <= OUT_W'(knot_reset(k));
            end
            fade_act <= 1'b0;
        end else begin
            if (wr_hit) shadow[wr_addr] <= wr_data;
            if (do_copy) active <= shadow;
            if (frame_start) fade_act <= fade_en;
        end
    end

    // R5
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(active));

    // R5
    copy_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && state_q == SH_PENDING) |=> (active == $past(shadow)));

    // R6
    fade_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(fade_act));

    // R4
    ignore_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_addr) >= N_KNOT) |=> $stable(shadow));

endmodule

// File: rtl/gamma_seg_decode.sv
module gamma_seg_decode
    import gamma_pkg::*;
(
    input  logic [IN_W-1:0]    pix,
    output logic [SEG_W-1:0]   seg,
    output logic [FRAC_W-1:0]  frac,
    output logic [SHIFT_W-1:0] shift
);

    localparam int SUB_MASK = (1 << SUB_BITS) - 1;

    int msb;
    int seg_i;
    int sh_i;
    int frac_i;

    always_comb begin
        msb = 0;
        for (int i = 0; i < IN_W; i++) begin
            if (pix[i]) msb = i;
        end
        if (msb < FINE_LIMIT) begin
            sh_i  = FINE_SHIFT;
            seg_i = int'(pix) >> FINE_SHIFT;
        end else begin
            sh_i  = msb - SUB_BITS;
            seg_i = FINE_SEGS + ((msb - FINE_LIMIT) << SUB_BITS)
                  + ((int'(pix) >> sh_i) & SUB_MASK);
        end
        frac_i = int'(pix) & ((1 << sh_i) - 1);
        seg    = SEG_W'(seg_i);
        frac   = FRAC_W'(frac_i);
        shift  = SHIFT_W'(sh_i);
    end

endmodule

// File: rtl/gamma_interp.sv
module gamma_interp
    import gamma_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_dark,
    input  logic [OUT_W-1:0]   y0,
    input  logic [OUT_W-1:0]   y1,
    input  logic [FRAC_W-1:0]  frac,
    input  logic [SHIFT_W-1:0] shift,
    output logic               out_valid,
    output logic [OUT_W-1:0]   out_pix
);

    logic signed [OUT_W:0]    diff;
    logic signed [PROD_W-1:0] prod;

    logic                     s2_valid;
    logic                     s2_dark;
    logic signed [PROD_W-1:0] s2_prod;
    logic [OUT_W-1:0]         s2_y0;
    logic [OUT_W-1:0]         s2_y1;
    logic [SHIFT_W-1:0]       s2_shift;

    logic signed [SUM_W-1:0]  prod_ext;
    logic signed [SUM_W-1:0]  half;
    logic signed [SUM_W-1:0]  step;
    logic signed [SUM_W-1:0]  sum;
    logic [OUT_W-1:0]         clamped;
    logic [OUT_W-1:0]         s2_lo;
    logic [OUT_W-1:0]         s2_hi;

    // stage 2 arithmetic: signed slope times fraction
    always_comb begin
        diff = $signed({1'b0, y1}) - $signed({1'b0, y0});
        prod = diff * $signed({1'b0, frac});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_dark  <= 1'b0;
            s2_prod  <= '0;
            s2_y0    <= '0;
            s2_y1    <= '0;
            s2_shift <= '0;
        end else begin
            s2_valid <= in_valid;
            if (in_valid) begin
                s2_dark  <= in_dark;
                s2_prod  <= prod;
                s2_y0    <= y0;
                s2_y1    <= y1;
                s2_shift <= shift;
            end
        end
    end

    // stage 3 arithmetic: round to nearest, add base, clamp
    always_comb begin
        prod_ext = SUM_W'(s2_prod);
        half     = SUM_W'(1) << (s2_shift - SHIFT_W'(1));
        step     = (prod_ext + half) >>> s2_shift;
        sum      = $signed({{(SUM_W-OUT_W){1'b0}}, s2_y0}) + step;
        if (sum[SUM_W-1]) begin
            clamped = '0;
        end else if (sum > $signed(SUM_W'(OUT_MAX))) begin
            clamped = OUT_W'(OUT_MAX);
        end else begin
            clamped = sum[OUT_W-1:0];
        end
        s2_lo = (s2_y0 < s2_y1) ? s2_y0 : s2_y1;
        s2_hi = (s2_y0 < s2_y1) ? s2_y1 : s2_y0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= s2_valid;
            out_pix   <= s2_valid ? clamped : '0;
        end
    end

    // R8
    within_knots_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s2_valid |=> (out_pix >= $past(s2_lo)) && (out_pix <= $past(s2_hi)));

    // R6
    dark_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid && s2_dark) |=> (out_pix == '0));

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_pix == '0));

    // R7
    stage_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

endmodule

// File: rtl/gamma_pwl.sv
module gamma_pwl
    import gamma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              fade_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [OUT_W-1:0]  wr_data,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_pix,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_pix
);

    curve_t             active;
    logic               fade_act;
    logic [SEG_W-1:0]   dec_seg;
    logic [FRAC_W-1:0]  dec_frac;
    logic [SHIFT_W-1:0] dec_shift;
    logic [ADDR_W-1:0]  seg_lo;
    logic [ADDR_W-1:0]  seg_hi;

    logic               s1_valid;
    logic               s1_dark;
    logic [OUT_W-1:0]   s1_y0;
    logic [OUT_W-1:0]   s1_y1;
    logic [FRAC_W-1:0]  s1_frac;
    logic [SHIFT_W-1:0] s1_shift;

    gamma_shadow_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .fade_en     (fade_en),
        .frame_start (frame_start),
        .active      (active),
        .fade_act    (fade_act)
    );

    gamma_seg_decode u_dec (
        .pix   (in_pix),
        .seg   (dec_seg),
        .frac  (dec_frac),
        .shift (dec_shift)
    );

    assign seg_lo = ADDR_W'(dec_seg);
    assign seg_hi = ADDR_W'(dec_seg) + ADDR_W'(1);

    // stage 1: knot lookup against the live curve
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_dark  <= 1'b0;
            s1_y0    <= '0;
            s1_y1    <= '0;
            s1_frac  <= '0;
            s1_shift <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_dark  <= fade_act;
                s1_y0    <= fade_act ? '0 : active[seg_lo];
                s1_y1    <= fade_act ? '0 : active[seg_hi];
                s1_frac  <= dec_frac;
                s1_shift <= dec_shift;
            end
        end
    end

    gamma_interp u_interp (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (s1_valid),
        .in_dark   (s1_dark),
        .y0        (s1_y0),
        .y1        (s1_y1),
        .frac      (s1_frac),
        .shift     (s1_shift),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );

    // R1
    frac_in_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> ((int'(s1_frac) >> s1_shift) == 0));

    // R7
    first_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> s1_valid);

endmodule

// File: tb/gamma_pwl_tb.sv
`timescale 1ns/1ps
module gamma_pwl_tb;

    localparam int POS [33] = '{0, 8, 16, 24, 32, 40, 48, 56, 64, 80, 96, 112,
                                128, 160, 192, 224, 256, 320, 384, 448, 512,
                                640, 768, 896, 1024, 1280, 1536, 1792, 2048,
                                2560, 3072, 3584, 4096};
    localparam int VEC [16] = '{0, 1, 7, 8, 63, 64, 65, 79, 80, 1000, 2047,
                                2048, 3000, 3584, 4000, 4095};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       fade_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [9:0] wr_data = '0;
    logic       in_valid = 1'b0;
    logic [11:0] in_pix = '0;
    logic       out_valid;
    logic [9:0] out_pix;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int cur [33];
    int sh [33];
    bit fade_m = 1'b0;

    always #5 clk = ~clk;

    gamma_pwl u_dut (
        .clk (clk), .rst_n (rst_n), .frame_start (frame_start),
        .fade_en (fade_en), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .in_valid (in_valid), .in_pix (in_pix),
        .out_valid (out_valid), .out_pix (out_pix)
    );

    function automatic int model(input int x);
        int k, w, num, q, y;
        if (fade_m) return 0;
        k = 0;
        for (int i = 0; i < 32; i++) if (x >= POS[i] && x < POS[i+1]) k = i;
        w   = POS[k+1] - POS[k];
        num = (cur[k+1] - cur[k]) * (x - POS[k]) + w / 2;
        q   = (num >= 0) ? num / w : -((-num + w - 1) / w);
        y   = cur[k] + q;
        if (y < 0) y = 0;
        if (y > 1023) y = 1023;
        return y;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_knot(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'(a); wr_data = 10'(d);
        if (a < 33) sh[a] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fs_pulse();
        @(negedge clk);
        frame_start = 1'b1;
        cur = sh;
        fade_m = fade_en;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic send_one(input int x, input string req);
        int e;
        e = model(x);
        @(negedge clk);
        in_valid = 1'b1; in_pix = 12'(x);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 early valid", int'(out_valid), 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R7 valid at 3", int'(out_valid), 1);
        chk(int'(out_pix) == e, req, int'(out_pix), e);
    endtask

    task automatic run_vectors(input string req);
        foreach (VEC[i]) send_one(VEC[i], req);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        int xs [4];
        int ex [4];
        int e_old, e_new;
        for (int k = 0; k < 33; k++) begin
            cur[k] = (POS[k] / 4 > 1023) ? 1023 : POS[k] / 4;
            sh[k]  = cur[k];
        end
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R7 reset valid", int'(out_valid), 0);
        chk(out_pix == 10'd0, "R7 reset data", int'(out_pix), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 idle after reset", int'(out_valid), 0);

        // R3 R1 R2: default curve over all vectors
        run_vectors("R3 default curve");

        // R5: shadow writes invisible before frame start
        for (int k = 0; k < 33; k++) wr_knot(k, (k * 37 + 11) % 1024);
        send_one(4095, "R5 old curve kept");
        send_one(64, "R5 old curve kept");
        fs_pulse();
        // R1 R2 R8: non-monotonic curve
        run_vectors("R1 R2 R8 programmed curve");

        // R8: falling curve
        for (int k = 0; k < 33; k++) wr_knot(k, 1023 - k * 31);
        fs_pulse();
        run_vectors("R8 falling curve");

        // R4: out-of-range addresses ignored
        wr_knot(40, 5);
        wr_knot(33, 5);
        wr_knot(63, 5);
        fs_pulse();
        run_vectors("R4 bad address ignored");

        // R2 rounding at exact half, rising and falling
        wr_knot(0, 0);
        wr_knot(1, 1);
        fs_pulse();
        send_one(4, "R2 half rounds up");
        send_one(3, "R2 below half");
        send_one(8, "R2 on knot");
        wr_knot(0, 1);
        wr_knot(1, 0);
        fs_pulse();
        send_one(4, "R2 R8 falling half");
        send_one(5, "R2 R8 falling past half");

        // R6: fade sampled only on frame start
        @(negedge clk);
        fade_en = 1'b1;
        send_one(3000, "R6 fade not yet applied");
        fs_pulse();
        run_vectors("R6 fade black");
        @(negedge clk);
        fade_en = 1'b0;
        send_one(3000, "R6 fade still held");
        fs_pulse();
        send_one(3000, "R6 fade released");

        // R5: pixel in the frame_start cycle uses old curve
        wr_knot(28, 900);
        wr_knot(29, 100);
        e_old = model(2100);
        @(negedge clk);
        frame_start = 1'b1; in_valid = 1'b1; in_pix = 12'd2100;
        @(negedge clk);
        cur = sh;
        e_new = model(2100);
        frame_start = 1'b0; in_valid = 1'b1; in_pix = 12'd2100;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk(int'(out_pix) == e_old, "R5 same-cycle pixel old curve", int'(out_pix), e_old);
        @(negedge clk);
        chk(int'(out_pix) == e_new, "R5 next pixel new curve", int'(out_pix), e_new);

        // R7: back-to-back burst
        xs = '{100, 4095, 0, 2560};
        foreach (xs[i]) ex[i] = model(xs[i]);
        for (int c = 0; c < 7; c++) begin
            @(negedge clk);
            if (c == 1 || c == 2)
                chk(out_valid == 1'b0, "R7 burst latency", int'(out_valid), 0);
            if (c >= 3) begin
                chk(out_valid == 1'b1, "R7 burst valid", int'(out_valid), 1);
                chk(int'(out_pix) == ex[c-3], "R7 burst data", int'(out_pix), ex[c-3]);
            end
            if (c < 4) begin
                in_valid = 1'b1; in_pix = 12'(xs[c]);
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 burst end", int'(out_valid), 0);
        chk(out_pix == 10'd0, "R7 idle data zero", int'(out_pix), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule